// File: doc/BRIEF.md
# Mixed-Decay Fixed-Off-Time Current Chopper

This block is the digital controller for one H-bridge that holds a motor winding's current at a trip level by chopping. When enabled it drives the diagonal switch pair chosen by the direction bit. It then waits for a synchronised current-sense trip flag. Trips that arrive during a blanking window after the on phase begins are ignored. A trip accepted after that window starts a fixed off time. The off time has three parts: fast decay, where the opposite diagonal pair is on; a short gap with every switch off; and slow decay, where both low-side switches are on. When the off time ends, the bridge goes back to the on phase and a new blanking window starts.

During decay the recirculation switches are on only until the zero-current flag is seen. From then until the next on phase, every switch is released so the winding current cannot reverse. Dropping the enable turns the bridge off. A direction change while the bridge is active also turns it off, and the bridge then waits through a non-overlap delay before it drives the new pair. All durations are parameters in clock cycles. One parameter picks the long or the short off time. The fast-decay share is a per-mille fraction of the off time.

Top module: `mixed_decay_chopper`

## Requirements
- R1: During and after reset, and while the enable is low, all four gate outputs are 0.
- R2: After the enable is sampled high in the off state, all gates stay off for GAP_CYC+1 cycles. Then the drive pair appears. Direction 1 drives hs_a and ls_b ({hs_a,ls_a,hs_b,ls_b} = 1001). Direction 0 drives hs_b and ls_a (0110).
- R3: A trip sampled in the first BLANK_CYC cycles of an on phase is ignored. A trip sampled later ends the on phase, and fast decay shows on the outputs one cycle later. With the trip held high, the on phase lasts BLANK_CYC+1 cycles.
- R4: Fast decay drives the diagonal pair opposite to the drive pair. It lasts FAST = floor(OFF x FAST_PERMILLE / 1000) cycles.
- R5: After fast decay, all four gates are off for DEAD_CYC cycles. The low-side pair is never switched on in the cycle after a high-side switch was on.
- R6: After the dead gap, slow decay turns on ls_a and ls_b (0101) for OFF - FAST - DEAD_CYC cycles. The next cycle returns to the drive pair and starts a new blanking window.
- R7: SHORT_OFF = 1 selects OFF = OFF_SHORT_CYC. SHORT_OFF = 0 selects OFF = OFF_LONG_CYC. FAST and the slow length are derived from OFF.
- R8: A zero-current flag sampled during fast decay, dead gap or slow decay turns all gates off from the next cycle until the next on phase.
- R9: The enable sampled low turns all gates off on the next cycle, whatever the phase.
- R10: A direction bit that differs from the latched direction during on, fast, dead or slow turns all gates off on the next cycle. The gates stay off for GAP_CYC cycles, and then the new drive pair is applied.
- R11: hs_a and ls_a are never both on, and hs_b and ls_b are never both on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Bridge enable |
| dir | input | 1 | Direction: 1 selects hs_a/ls_b, 0 selects hs_b/ls_a |
| trip | input | 1 | Synchronised current-sense comparator trip |
| zero_cur | input | 1 | Synchronised zero-current detect |
| hs_a | output | 1 | High-side switch command, leg A |
| ls_a | output | 1 | Low-side switch command, leg A |
| hs_b | output | 1 | High-side switch command, leg B |
| ls_b | output | 1 | Low-side switch command, leg B |

## Verification
The properties assume that trip and zero_cur are already synchronised to clk and that each is one sampled value per cycle. They also assume reset is held high at time zero, so the previous-cycle checks see reset-cleared gates. The stimulus changes every input only on the falling edge. It pulses trip inside the blanking window and holds it high later. It pulses zero_cur in both fast and slow decay. It changes direction in the middle of fast decay and drops the enable during an on phase. A long-off and a short-off instance run side by side against behavioural models that are compared every cycle.

// File: rtl/mdchop_pkg.sv
package mdchop_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GAP,
        PH_DRIVE,
        PH_FAST,
        PH_DEAD,
        PH_SLOW
    } phase_e;

    typedef struct packed {
        logic hi_a;
        logic lo_a;
        logic hi_b;
        logic lo_b;
    } gate_t;

    localparam gate_t GATES_OFF = '0;

    // Diagonal pair: fwd=1 -> high A with low B, fwd=0 -> high B with low A
    function automatic gate_t diag_pair(input logic fwd);
        gate_t g;
        g.hi_a = fwd;
        g.lo_b = fwd;
        g.hi_b = !fwd;
        g.lo_a = !fwd;
        return g;
    endfunction

    function automatic gate_t low_pair();
        gate_t g;
        g = GATES_OFF;
        g.lo_a = 1'b1;
        g.lo_b = 1'b1;
        return g;
    endfunction

    function automatic int fast_share(input int off_cyc, input int permille);
        return (off_cyc * permille) / 1000;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/mdchop_timer.sv
module mdchop_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign expired = (cnt == '0);

    // R3: once the window has run out it stays out until reloaded
    p_hold_expired_r3: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired);

endmodule

// File: rtl/mdchop_gate_map.sv
module mdchop_gate_map
    import mdchop_pkg::*;
(
    input  phase_e ph,
    input  logic   fwd,
    input  logic   sr_cut,
    output gate_t  g
);

    always_comb begin
        unique case (ph)
            PH_DRIVE: g = diag_pair(fwd);
            PH_FAST:  g = sr_cut ? GATES_OFF : diag_pair(!fwd);
            PH_SLOW:  g = sr_cut ? GATES_OFF : low_pair();
            default:  g = GATES_OFF;
        endcase
    end

endmodule

// File: rtl/mixed_decay_chopper.sv
module mixed_decay_chopper
    import mdchop_pkg::*;
#(
    parameter int OFF_LONG_CYC  = 3750,
    parameter int OFF_SHORT_CYC = 1013,
    parameter bit SHORT_OFF     = 1'b0,
    parameter int FAST_PERMILLE = 301,
    parameter int DEAD_CYC      = 75,
    parameter int BLANK_CYC     = 125,
    parameter int GAP_CYC       = 54
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic dir,
    input  logic trip,
    input  logic zero_cur,
    output logic hs_a,
    output logic ls_a,
    output logic hs_b,
    output logic ls_b
);

    localparam int OFF_CYC  = SHORT_OFF ? OFF_SHORT_CYC : OFF_LONG_CYC;
    localparam int FAST_CYC = fast_share(OFF_CYC, FAST_PERMILLE);
    localparam int SLOW_CYC = OFF_CYC - FAST_CYC - DEAD_CYC;
    localparam int CW       = $clog2(max3(OFF_CYC, BLANK_CYC, GAP_CYC) + 1);

    phase_e        st, nxt;
    logic          dir_q, dir_d;
    logic          zc_q, zc_d;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic          tmr_done;
    logic          active;
    logic          decay;
    gate_t         g;

    assign active = (st == PH_DRIVE) || (st == PH_FAST) ||
                    (st == PH_DEAD)  || (st == PH_SLOW);
    assign decay  = (st == PH_FAST) || (st == PH_DEAD) || (st == PH_SLOW);

    always_comb begin
        nxt = st;
        if (!en) begin
            nxt = PH_IDLE;
        end else if (active && (dir != dir_q)) begin
            nxt = PH_GAP;
        end else begin
            unique case (st)
                PH_IDLE:  nxt = PH_GAP;
                PH_GAP:   if (tmr_done) nxt = PH_DRIVE;
                PH_DRIVE: if (tmr_done && trip) nxt = PH_FAST;
                PH_FAST:  if (tmr_done) nxt = PH_DEAD;
                PH_DEAD:  if (tmr_done) nxt = PH_SLOW;
                PH_SLOW:  if (tmr_done) nxt = PH_DRIVE;
                default:  nxt = PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ld     = (nxt != st);
        ld_val = '0;
        unique case (nxt)
            PH_GAP:   ld_val = CW'(GAP_CYC - 1);
            PH_DRIVE: ld_val = CW'(BLANK_CYC);
            PH_FAST:  ld_val = CW'(FAST_CYC - 1);
            PH_DEAD:  ld_val = CW'(DEAD_CYC - 1);
            PH_SLOW:  ld_val = CW'(SLOW_CYC - 1);
            default:  ld_val = '0;
        endcase
    end

    always_comb begin
        dir_d = dir_q;
        zc_d  = zc_q;
        if ((nxt == PH_DRIVE) && (st != PH_DRIVE)) begin
            dir_d = dir;
            zc_d  = 1'b0;
        end else if (decay && zero_cur) begin
            zc_d  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= PH_IDLE;
            dir_q <= 1'b0;
            zc_q  <= 1'b0;
        end else begin
            st    <= nxt;
            dir_q <= dir_d;
            zc_q  <= zc_d;
        end
    end

    mdchop_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .expired  (tmr_done)
    );

    mdchop_gate_map u_map (
        .ph     (st),
        .fwd    (dir_q),
        .sr_cut (zc_q),
        .g      (g)
    );

    assign hs_a = g.hi_a;
    assign ls_a = g.lo_a;
    assign hs_b = g.hi_b;
    assign ls_b = g.lo_b;

    // R11: no leg ever has both switches on
    p_leg_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(hs_a && ls_a) && !(hs_b && ls_b));

    // R5: low-side pair never follows a high-side switch directly
    p_dead_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (ls_a && ls_b) |-> !($past(hs_a) || $past(hs_b)));

    // R9: enable low releases every switch on the next cycle
    p_disable_off_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!hs_a && !ls_a && !hs_b && !ls_b));

    // R10: direction change while active releases every switch
    p_redir_off_r10: assert property (@(posedge clk) disable iff (rst)
        (en && active && (dir != dir_q)) |=> (!hs_a && !ls_a && !hs_b && !ls_b));

    // R8: zero current during decay cuts rectification unless a new on phase begins
    p_zero_cut_r8: assert property (@(posedge clk) disable iff (rst)
        (decay && zero_cur) |=> ((!hs_a && !ls_a && !hs_b && !ls_b) || (st == PH_DRIVE)));

    // R3: inside the blanking window the on phase is held
    p_blank_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ((st == PH_DRIVE) && en && (dir == dir_q) && !tmr_done) |=> (st == PH_DRIVE));

endmodule

// File: tb/mixed_decay_chopper_tb.sv
`timescale 1ns/1ps

module mdchop_ref #(
    parameter int OFF      = 200,
    parameter int PERMILLE = 301,
    parameter int DEAD     = 6,
    parameter int BLANK    = 10,
    parameter int GAP      = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       dir,
    input  logic       trip,
    input  logic       zero,
    output logic [3:0] g,
    output int         ph
);
    // phase: 0 off, 1 gap, 2 on, 3 fast, 4 dead, 5 slow
    int fast_n;
    int slow_n;
    int el;
    bit dq;
    bit zc;

    initial begin
        fast_n = (OFF * PERMILLE) / 1000;
        slow_n = OFF - fast_n - DEAD;
        ph = 0;
        el = 0;
        dq = 0;
        zc = 0;
    end

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; el = 0; dq = 0; zc = 0;
        end else if (!en) begin
            ph = 0; el = 0;
        end else if (ph >= 2 && dir != dq) begin
            ph = 1; el = 0;
        end else begin
            if (ph >= 3 && zero) zc = 1;
            case (ph)
                0: begin ph = 1; el = 0; end
                1: if (el == GAP - 1) begin ph = 2; el = 0; dq = dir; zc = 0; end
                   else el++;
                2: if (trip && el >= BLANK) begin ph = 3; el = 0; end
                   else el++;
                3: if (el == fast_n - 1) begin ph = 4; el = 0; end else el++;
                4: if (el == DEAD - 1) begin ph = 5; el = 0; end else el++;
                default: if (el == slow_n - 1) begin ph = 2; el = 0; zc = 0; end
                   else el++;
            endcase
        end
    end

    always_comb begin
        case (ph)
            2: g = dq ? 4'b1001 : 4'b0110;
            3: g = zc ? 4'b0000 : (dq ? 4'b0110 : 4'b1001);
            5: g = zc ? 4'b0000 : 4'b0101;
            default: g = 4'b0000;
        endcase
    end
endmodule

module mixed_decay_chopper_tb;

    localparam int OFF_L = 200;
    localparam int OFF_S = 60;
    localparam int DEAD  = 6;
    localparam int BLANK = 10;
    localparam int GAP   = 7;
    localparam int FAST_L = (OFF_L * 301) / 1000;
    localparam int FAST_S = (OFF_S * 301) / 1000;
    localparam int SLOW_L = OFF_L - FAST_L - DEAD;
    localparam int SLOW_S = OFF_S - FAST_S - DEAD;

    logic clk = 0;
    logic rst = 1;
    logic en = 0, dir = 1, trip = 0, zero_cur = 0;
    logic hs_a, ls_a, hs_b, ls_b;
    logic ahs_a, als_a, ahs_b, als_b;
    logic [3:0] ref_g, ref_ga;
    int ref_ph, ref_pha;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mixed_decay_chopper #(.OFF_LONG_CYC(OFF_L), .OFF_SHORT_CYC(OFF_S), .SHORT_OFF(1'b0),
        .FAST_PERMILLE(301), .DEAD_CYC(DEAD), .BLANK_CYC(BLANK), .GAP_CYC(GAP)) u_dut (
        .clk(clk), .rst(rst), .en(en), .dir(dir), .trip(trip), .zero_cur(zero_cur),
        .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b));

    mixed_decay_chopper #(.OFF_LONG_CYC(OFF_L), .OFF_SHORT_CYC(OFF_S), .SHORT_OFF(1'b1),
        .FAST_PERMILLE(301), .DEAD_CYC(DEAD), .BLANK_CYC(BLANK), .GAP_CYC(GAP)) u_dut_alt (
        .clk(clk), .rst(rst), .en(en), .dir(dir), .trip(trip), .zero_cur(zero_cur),
        .hs_a(ahs_a), .ls_a(als_a), .hs_b(ahs_b), .ls_b(als_b));

    mdchop_ref #(.OFF(OFF_L), .DEAD(DEAD), .BLANK(BLANK), .GAP(GAP)) u_ref (
        .clk(clk), .rst(rst), .en(en), .dir(dir), .trip(trip), .zero(zero_cur),
        .g(ref_g), .ph(ref_ph));

    mdchop_ref #(.OFF(OFF_S), .DEAD(DEAD), .BLANK(BLANK), .GAP(GAP)) u_ref_alt (
        .clk(clk), .rst(rst), .en(en), .dir(dir), .trip(trip), .zero(zero_cur),
        .g(ref_ga), .ph(ref_pha));

    function automatic logic [3:0] cur(input bit alt);
        return alt ? {ahs_a, als_a, ahs_b, als_b} : {hs_a, ls_a, hs_b, ls_b};
    endfunction

    function automatic string phase_tag(input int ph, input bit alt);
        if (alt) return "R7";
        case (ph)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cmp(input logic [3:0] act, input logic [3:0] exp, input int ph, input bit alt);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (cycle model, %s): actual %b expected %b",
                     phase_tag(ph, alt), alt ? "short" : "long", act, exp);
        end
        checks++;
        if ((act[3] && act[2]) || (act[1] && act[0])) begin
            errors++;
            $display("FAIL R11: actual %b expected no leg overlap", act);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            cmp(cur(0), ref_g, ref_ph, 0);
            cmp(cur(1), ref_ga, ref_pha, 1);
        end
    end

    task automatic wait_for(input logic [3:0] pat, input bit alt);
        for (int k = 0; k < 5000 && cur(alt) != pat; k++) @(negedge clk);
    endtask

    task automatic wait_not(input logic [3:0] pat, input bit alt);
        for (int k = 0; k < 5000 && cur(alt) == pat; k++) @(negedge clk);
    endtask

    task automatic run_len(input logic [3:0] pat, input bit alt, output int n);
        n = 0;
        wait_for(pat, alt);
        while (cur(alt) == pat && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        chk("R1 reset long", int'(cur(0)), 0);
        chk("R1 reset short", int'(cur(1)), 0);
        rst = 0;
        @(negedge clk);
        chk("R1 enable low", int'(cur(0)), 0);

        // R2: enable, count off cycles before the drive pair
        en = 1;
        n = 0;
        do begin @(negedge clk); n++; end while (cur(0) == 4'b0000 && n < 100);
        chk("R2 off cycles before drive", n, GAP + 1);
        chk("R2 dir1 drive pair", int'(cur(0)), 4'b1001);

        // R3: trip inside blanking is ignored
        trip = 1;
        repeat (5) @(negedge clk);
        trip = 0;
        repeat (10) @(negedge clk);
        chk("R3 blanked trip ignored", int'(cur(0)), 4'b1001);
        trip = 1;
        @(negedge clk);
        chk("R3 trip ends on phase", int'(cur(0)), 4'b0110);

        run_len(4'b0110, 0, n);
        chk("R4 fast length", n, FAST_L);
        run_len(4'b0000, 0, n);
        chk("R5 dead gap length", n, DEAD);
        run_len(4'b0101, 0, n);
        chk("R6 slow length", n, SLOW_L);
        chk("R6 return to drive", int'(cur(0)), 4'b1001);
        run_len(4'b1001, 0, n);
        chk("R3 on length with trip held", n, BLANK + 1);

        // R7: short-off variant
        wait_not(4'b0110, 1);
        run_len(4'b0110, 1, n);
        chk("R7 short fast length", n, FAST_S);
        run_len(4'b0000, 1, n);
        chk("R7 short dead length", n, DEAD);
        run_len(4'b0101, 1, n);
        chk("R7 short slow length", n, SLOW_S);

        // R8: zero current during slow decay
        wait_not(4'b0101, 0);
        wait_for(4'b0101, 0);
        zero_cur = 1;
        @(negedge clk);
        zero_cur = 0;
        chk("R8 slow cut", int'(cur(0)), 0);
        n = 0;
        while (cur(0) == 4'b0000 && n < 1000) begin n++; @(negedge clk); end
        chk("R8 next on phase", int'(cur(0)), 4'b1001);

        // R8: zero current during fast decay
        wait_for(4'b0110, 0);
        zero_cur = 1;
        @(negedge clk);
        zero_cur = 0;
        chk("R8 fast cut", int'(cur(0)), 0);

        // R10: direction change during fast decay
        wait_for(4'b1001, 0);
        wait_for(4'b0110, 0);
        dir = 0;
        @(negedge clk);
        chk("R10 immediate off", int'(cur(0)), 0);
        n = 0;
        while (cur(0) == 4'b0000 && n < 100) begin n++; @(negedge clk); end
        chk("R10 gap length", n, GAP);
        chk("R10 dir0 drive pair", int'(cur(0)), 4'b0110);

        // R9: enable drop during on phase
        en = 0;
        @(negedge clk);
        chk("R9 off after disable", int'(cur(0)), 0);
        repeat (20) @(negedge clk);
        chk("R9 stays off", int'(cur(0)), 0);
        chk("R9 short stays off", int'(cur(1)), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule